// File: doc/BRIEF.md
# Ethernet MAC Interrupt and Control Registers

This block is the register front end of a small Ethernet MAC. It sits on a 32-bit memory-mapped bus with a single-cycle write strobe and a combinational read port. It holds seven raw interrupt status flags and a matching enable mask. It also holds the receive and transmit control settings, the 48-bit station address, a transmit threshold and a management clock divider. One level-sensitive interrupt line leaves the block.

The TX and RX datapaths raise status flags through a per-source set vector. Software reads the raw flags and clears them with a write-one-to-clear acknowledge. Two register writes have side effects, delivered as one-cycle strobes to the datapaths. An acknowledge that clears the TX-error flag also flushes the transmit buffer. A receive-control write with the queue-reset bit set empties the receive queue.

Top module: `eth_irq_regs`

## Requirements
- R1: Status flags use this encoding: bit0 frame received, bit1 transmit error, bit2 transmit buffer empty, bit3 FIFO overrun, bit4 receive error, bit5 management done, bit6 PHY event. A high bit on `evt_set` sets the matching flag at the next clock edge. The flags read back at offset 0x00 in bits 6:0, and the upper bits read as zero. With no event and no acknowledge, the flags hold.
- R2: `irq` is high exactly when status AND mask is non-zero. It follows the registers updated at the edge of any status or mask change. The mask is written and read at offset 0x04, bits 6:0.
- R3: A write to offset 0x00 clears each status flag whose data bit is one. An event arriving in the same cycle for the same flag wins over the clear.
- R4: A write to offset 0x00 with data bit1 set drives `tx_flush` high for exactly the one cycle after the write edge.
- R5: Receive control at offset 0x08 stores enable (bit0), multicast accept (bit1), promiscuous (bit2) and bad-CRC pass (bit3), and these drive `rx_ctrl`. Data bit4 is not stored and reads as zero. When written as one, bit4 drives `rx_qreset` high for the one cycle after the write edge.
- R6: Transmit control at offset 0x0C stores enable (bit0), pad (bit1), auto-CRC (bit2) and full duplex (bit3) on `tx_ctrl`, and it reads back in bits 3:0.
- R7: After a synchronous active-low reset, these values hold: status 0, mask 0x7F, receive control 0x08, transmit control 0, station address 0, threshold 0x3F, divider 0x80. `tx_flush` and `rx_qreset` are low.
- R8: Station address bytes 0 to 3 sit at offset 0x14, with byte 0 in bits 7:0 and the rest in little-endian order. Bytes 4 and 5 sit at offset 0x18, bits 15:0. Byte k drives `mac_addr[8k+7:8k]`.
- R9: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x14, 0x18, 0x1C and 0x24 return zero. Writes to those other offsets change no register and raise no strobe.
- R10: The transmit threshold at offset 0x1C (bits 5:0) and the management divider at offset 0x24 (bits 7:0) are stored, read back and driven on `tx_thresh` and `mdio_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_set | input | 7 | Per-source status set events from the datapaths |
| irq | output | 1 | Level interrupt, status AND mask non-zero |
| tx_flush | output | 1 | One-cycle transmit buffer flush strobe |
| rx_qreset | output | 1 | One-cycle receive queue reset strobe |
| rx_ctrl | output | 4 | Receive control settings |
| tx_ctrl | output | 4 | Transmit control settings |
| mac_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| tx_thresh | output | 6 | Transmit threshold |
| mdio_div | output | 8 | Management clock divider |

## Verification
The status path is tested first with a burst that sets every flag together. An acknowledge then clears all flags while one event lands on a flag in the same cycle. Only that flag should survive, which separates set priority from a plain clear. Sparse random events combined with random acknowledge and mask writes then exercise `irq`. Mask-only changes, status-only changes and their overlap each produce a distinct expected level. Random writes and reads across both mapped and unmapped offsets check data placement and side-effect strobes. Acknowledges with and without bit1, and receive-control writes with and without bit4, show that each strobe depends on its own bit alone.

// File: rtl/eth_irq_pkg.sv
// Package: shared constants for the MAC interrupt/control register block.
// Assumes word-aligned byte offsets that fit in 12 bits.
package eth_irq_pkg;
    localparam int SRC_N    = 7;
    localparam int SRC_TXER = 1;
    localparam int RCTL_W   = 4;
    localparam int RCTL_QRS = 4;
    localparam int TCTL_W   = 4;
    localparam int THR_W    = 6;
    localparam int DIV_W    = 8;
    localparam int MAC_W    = 48;
    localparam int DATA_W   = 32;
    localparam int OFF_W    = 12;

    localparam logic [OFF_W-1:0] OFF_STAT  = 12'h000;
    localparam logic [OFF_W-1:0] OFF_MASK  = 12'h004;
    localparam logic [OFF_W-1:0] OFF_RCTL  = 12'h008;
    localparam logic [OFF_W-1:0] OFF_TCTL  = 12'h00C;
    localparam logic [OFF_W-1:0] OFF_MACLO = 12'h014;
    localparam logic [OFF_W-1:0] OFF_MACHI = 12'h018;
    localparam logic [OFF_W-1:0] OFF_THR   = 12'h01C;
    localparam logic [OFF_W-1:0] OFF_DIV   = 12'h024;

    localparam logic [SRC_N-1:0]  MASK_INIT = 7'h7F;
    localparam logic [RCTL_W-1:0] RCTL_INIT = 4'h8;
    localparam logic [THR_W-1:0]  THR_INIT  = 6'h3F;
    localparam logic [DIV_W-1:0]  DIV_INIT  = 8'h80;
endpackage

// File: rtl/eth_irq_bus.sv
// Module: eth_irq_bus
// Decodes the byte offset into per-register write strobes and selects
// read data. Assumes ADDR_W <= 12 and a full-address match (no aliasing).
// Unmapped offsets produce no strobe and read as zero.
module eth_irq_bus
    import eth_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [SRC_N-1:0]  status,
    input  logic [SRC_N-1:0]  mask,
    input  logic [RCTL_W-1:0] rctl,
    input  logic [TCTL_W-1:0] tctl,
    input  logic [MAC_W-1:0]  mac,
    input  logic [THR_W-1:0]  thr,
    input  logic [DIV_W-1:0]  div,
    output logic              wr_stat,
    output logic              wr_mask,
    output logic              wr_rctl,
    output logic              wr_tctl,
    output logic              wr_maclo,
    output logic              wr_machi,
    output logic              wr_thr,
    output logic              wr_div,
    output logic [DATA_W-1:0] rdata
);
    logic hit_stat, hit_mask, hit_rctl, hit_tctl;
    logic hit_maclo, hit_machi, hit_thr, hit_div;

    // Offset comparators.
    always_comb begin
        hit_stat  = (bus_addr == OFF_STAT[ADDR_W-1:0]);
        hit_mask  = (bus_addr == OFF_MASK[ADDR_W-1:0]);
        hit_rctl  = (bus_addr == OFF_RCTL[ADDR_W-1:0]);
        hit_tctl  = (bus_addr == OFF_TCTL[ADDR_W-1:0]);
        hit_maclo = (bus_addr == OFF_MACLO[ADDR_W-1:0]);
        hit_machi = (bus_addr == OFF_MACHI[ADDR_W-1:0]);
        hit_thr   = (bus_addr == OFF_THR[ADDR_W-1:0]);
        hit_div   = (bus_addr == OFF_DIV[ADDR_W-1:0]);
    end

    // Write strobes: qualified by the bus write.
    always_comb begin
        wr_stat  = bus_wr && hit_stat;
        wr_mask  = bus_wr && hit_mask;
        wr_rctl  = bus_wr && hit_rctl;
        wr_tctl  = bus_wr && hit_tctl;
        wr_maclo = bus_wr && hit_maclo;
        wr_machi = bus_wr && hit_machi;
        wr_thr   = bus_wr && hit_thr;
        wr_div   = bus_wr && hit_div;
    end

    // Read mux, zero for unmapped offsets.
    always_comb begin
        rdata = '0;
        if (hit_stat)  rdata = DATA_W'(status);
        if (hit_mask)  rdata = DATA_W'(mask);
        if (hit_rctl)  rdata = DATA_W'(rctl);
        if (hit_tctl)  rdata = DATA_W'(tctl);
        if (hit_maclo) rdata = mac[31:0];
        if (hit_machi) rdata = DATA_W'(mac[MAC_W-1:32]);
        if (hit_thr)   rdata = DATA_W'(thr);
        if (hit_div)   rdata = DATA_W'(div);
    end
endmodule

// File: rtl/eth_irq_status.sv
// Module: eth_irq_status
// Raw interrupt flags with write-one-to-clear acknowledge, the enable
// mask and the level interrupt. A set event in the same cycle as a clear
// of the same flag wins. Assumes one-cycle write strobes.
module eth_irq_status
    import eth_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_wr,
    input  logic [SRC_N-1:0] ack_bits,
    input  logic             mask_wr,
    input  logic [SRC_N-1:0] mask_bits,
    input  logic [SRC_N-1:0] evt_set,
    output logic [SRC_N-1:0] status,
    output logic [SRC_N-1:0] mask,
    output logic             irq
);
    logic [SRC_N-1:0] clr_vec;

    // Clear vector, active only during an acknowledge write.
    always_comb clr_vec = ack_wr ? ack_bits : '0;

    // Per-source flag: set beats clear.
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           status[i] <= 1'b0;
            else if (evt_set[i])  status[i] <= 1'b1;
            else if (clr_vec[i])  status[i] <= 1'b0;
        end
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= MASK_INIT;
        else if (mask_wr) mask <= mask_bits;
    end

    // Level interrupt from enabled flags.
    always_comb irq = |(status & mask);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set))); // R1
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && evt_set == '0) |=> $stable(status)); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((status & $past(ack_bits & ~evt_set)) == '0)); // R3
    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_bits == '0) |=> !irq); // R2
endmodule

// File: rtl/eth_irq_cfg.sv
// Module: eth_irq_cfg
// Receive/transmit control, station address, threshold and divider
// registers, plus the two registered side-effect strobes. Assumes the
// write strobes are mutually exclusive and last one cycle.
module eth_irq_cfg
    import eth_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_rctl,
    input  logic              wr_tctl,
    input  logic              wr_maclo,
    input  logic              wr_machi,
    input  logic              wr_thr,
    input  logic              wr_div,
    input  logic [DATA_W-1:0] wdata,
    output logic [RCTL_W-1:0] rctl,
    output logic [TCTL_W-1:0] tctl,
    output logic [MAC_W-1:0]  mac,
    output logic [THR_W-1:0]  thr,
    output logic [DIV_W-1:0]  div,
    output logic              tx_flush,
    output logic              rx_qreset
);
    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rctl <= RCTL_INIT;
            tctl <= '0;
        end else begin
            if (wr_rctl) rctl <= wdata[RCTL_W-1:0];
            if (wr_tctl) tctl <= wdata[TCTL_W-1:0];
        end
    end

    // Station address halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac <= '0;
        end else begin
            if (wr_maclo) mac[31:0]       <= wdata;
            if (wr_machi) mac[MAC_W-1:32] <= wdata[MAC_W-33:0];
        end
    end

    // Threshold and divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= THR_INIT;
            div <= DIV_INIT;
        end else begin
            if (wr_thr) thr <= wdata[THR_W-1:0];
            if (wr_div) div <= wdata[DIV_W-1:0];
        end
    end

    // One-cycle side-effect strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush  <= 1'b0;
            rx_qreset <= 1'b0;
        end else begin
            tx_flush  <= wr_stat && wdata[SRC_TXER];
            rx_qreset <= wr_rctl && wdata[RCTL_QRS];
        end
    end

    AST_FLUSH_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[SRC_TXER]) |=> tx_flush); // R4
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(wr_stat && wdata[SRC_TXER])); // R4
    AST_QRST_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rctl && wdata[RCTL_QRS]) |=> rx_qreset); // R5
    AST_QRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_qreset |-> $past(wr_rctl && wdata[RCTL_QRS])); // R5
endmodule

// File: rtl/eth_irq_regs.sv
// Module: eth_irq_regs (top)
// Interrupt and control register front end of a small Ethernet MAC.
// Writes take effect at the clock edge of the write strobe; reads are
// combinational. Assumes a 32-bit bus and ADDR_W <= 12.
module eth_irq_regs
    import eth_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [6:0]        evt_set,
    output logic              irq,
    output logic              tx_flush,
    output logic              rx_qreset,
    output logic [3:0]        rx_ctrl,
    output logic [3:0]        tx_ctrl,
    output logic [47:0]       mac_addr,
    output logic [5:0]        tx_thresh,
    output logic [7:0]        mdio_div
);
    logic [SRC_N-1:0] status, mask;
    logic wr_stat, wr_mask, wr_rctl, wr_tctl, wr_maclo, wr_machi, wr_thr, wr_div;

    eth_irq_bus #(.ADDR_W(ADDR_W)) u_bus (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .status   (status),
        .mask     (mask),
        .rctl     (rx_ctrl),
        .tctl     (tx_ctrl),
        .mac      (mac_addr),
        .thr      (tx_thresh),
        .div      (mdio_div),
        .wr_stat  (wr_stat),
        .wr_mask  (wr_mask),
        .wr_rctl  (wr_rctl),
        .wr_tctl  (wr_tctl),
        .wr_maclo (wr_maclo),
        .wr_machi (wr_machi),
        .wr_thr   (wr_thr),
        .wr_div   (wr_div),
        .rdata    (bus_rdata)
    );

    eth_irq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_wr    (wr_stat),
        .ack_bits  (bus_wdata[SRC_N-1:0]),
        .mask_wr   (wr_mask),
        .mask_bits (bus_wdata[SRC_N-1:0]),
        .evt_set   (evt_set),
        .status    (status),
        .mask      (mask),
        .irq       (irq)
    );

    eth_irq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stat   (wr_stat),
        .wr_rctl   (wr_rctl),
        .wr_tctl   (wr_tctl),
        .wr_maclo  (wr_maclo),
        .wr_machi  (wr_machi),
        .wr_thr    (wr_thr),
        .wr_div    (wr_div),
        .wdata     (bus_wdata),
        .rctl      (rx_ctrl),
        .tctl      (tx_ctrl),
        .mac       (mac_addr),
        .thr       (tx_thresh),
        .div       (mdio_div),
        .tx_flush  (tx_flush),
        .rx_qreset (rx_qreset)
    );

    AST_RST_STROBES: assert property (@(posedge clk)
        !rst_n |=> (!tx_flush && !rx_qreset && status == '0)); // R7
endmodule

// File: tb/eth_irq_regs_bench.sv
`timescale 1ns/1ps
module eth_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_set = '0;
    logic        irq, tx_flush, rx_qreset;
    logic [3:0]  rx_ctrl, tx_ctrl;
    logic [47:0] mac_addr;
    logic [5:0]  tx_thresh;
    logic [7:0]  mdio_div;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state
    logic [6:0]  m_st = '0, m_msk = 7'h7F;
    logic [3:0]  m_rc = 4'h8, m_tc = '0;
    logic [47:0] m_mac = '0;
    logic [5:0]  m_thr = 6'h3F;
    logic [7:0]  m_div = 8'h80;
    logic        m_flush = 0, m_qr = 0;

    always #2.5 clk = ~clk;

    eth_irq_regs #(.ADDR_W(8)) u_eth_irq_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq(irq), .tx_flush(tx_flush), .rx_qreset(rx_qreset),
        .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl), .mac_addr(mac_addr),
        .tx_thresh(tx_thresh), .mdio_div(mdio_div)
    );

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        case (a)
            8'h00: return {25'd0, m_st};
            8'h04: return {25'd0, m_msk};
            8'h08: return {28'd0, m_rc};
            8'h0C: return {28'd0, m_tc};
            8'h14: return m_mac[31:0];
            8'h18: return {16'd0, m_mac[47:32]};
            8'h1C: return {26'd0, m_thr};
            8'h24: return {24'd0, m_div};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h00: return "R1";
            8'h04: return "R2";
            8'h08: return "R5";
            8'h0C: return "R6";
            8'h14, 8'h18: return "R8";
            8'h1C, 8'h24: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, update the model at the edge, check after it.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [6:0] e);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; evt_set = e;
        @(posedge clk);
        m_flush = 0; m_qr = 0;
        if (w) begin
            case (a)
                8'h00: begin m_st = m_st & ~d[6:0]; m_flush = d[1]; end
                8'h04: m_msk = d[6:0];
                8'h08: begin m_rc = d[3:0]; m_qr = d[4]; end
                8'h0C: m_tc = d[3:0];
                8'h14: m_mac[31:0] = d;
                8'h18: m_mac[47:32] = d[15:0];
                8'h1C: m_thr = d[5:0];
                8'h24: m_div = d[7:0];
                default: ;
            endcase
        end
        m_st = m_st | e;
        #1;
        chk(addr_tag(a), 48'(bus_rdata), 48'(ref_read(a)));
        chk("R2 irq", 48'(irq), 48'(|(m_st & m_msk)));
        chk("R4 tx_flush", 48'(tx_flush), 48'(m_flush));
        chk("R5 rx_qreset", 48'(rx_qreset), 48'(m_qr));
        chk("R5 rx_ctrl", 48'(rx_ctrl), 48'(m_rc));
        chk("R6 tx_ctrl", 48'(tx_ctrl), 48'(m_tc));
        chk("R8 mac_addr", mac_addr, m_mac);
        chk("R10 thr/div", 48'({tx_thresh, mdio_div}), 48'({m_thr, m_div}));
    endtask

    initial begin
        logic [7:0] offs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h3C};
        void'($urandom(32'd20190));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R7: reset values read back through every offset
        for (int i = 0; i < 12; i++) begin
            step(0, offs[i], 32'd0, 7'd0);
            chk("R7 reset read", 48'(bus_rdata), 48'(ref_read(offs[i])));
        end
        // R3: full set, then clear-all racing one event
        step(1, 8'h04, 32'h0, 7'h7F);
        chk("R2 masked off", 48'(irq), 48'd0);
        step(1, 8'h00, 32'h7F, 7'h04);
        chk("R3 event beats ack", 48'({25'd0, m_st}), 48'h04);
        step(0, 8'h00, 32'd0, 7'd0);
        chk("R3 status readback", 48'(bus_rdata), 48'h04);
        // R2: enabling the pending flag raises irq
        step(1, 8'h04, 32'h04, 7'd0);
        chk("R2 irq rises", 48'(irq), 48'd1);
        // R4: ack with bit1 flushes, next cycle strobe drops
        step(1, 8'h00, 32'h02, 7'd0);
        chk("R4 flush pulse", 48'(tx_flush), 48'd1);
        step(0, 8'h00, 32'd0, 7'd0);
        chk("R4 flush one cycle", 48'(tx_flush), 48'd0);
        // R5: queue reset bit strobes, not stored
        step(1, 8'h08, 32'h1F, 7'd0);
        chk("R5 qreset pulse", 48'(rx_qreset), 48'd1);
        step(0, 8'h08, 32'd0, 7'd0);
        chk("R5 bit4 reads zero", 48'(bus_rdata), 48'h0F);
        // R9: unmapped writes change nothing
        step(1, 8'h10, 32'hFFFF_FFFF, 7'd0);
        step(1, 8'h3C, 32'hFFFF_FFFF, 7'd0);
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [6:0] e;
            e = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
            step(($urandom % 2) == 1, offs[$urandom % 12], $urandom, e);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule